// File: doc/BRIEF.md
# Bit-Serial Shift Unit

This block shifts a word that moves through the datapath one bit per cycle, least significant bit first. It has no multiplexer tree. It shifts by timing alone: the position of the data relative to the output window decides the shift distance. Three operations are supported: logical shift left, logical shift right and arithmetic shift right.

A transfer starts with a one-cycle `start_i` pulse while the block is idle. On that edge the block captures the direction, the arithmetic flag and the shift distance. A load phase of `WIDTH` cycles follows, during which the operand is taken from `ser_i`. The block then produces a result window of `WIDTH` cycles, during which `wr_en_o` is high and `ser_o` carries the result bits.

For a left shift the window opens at once. The stored operand is held back until the distance counter runs out, so the low result bits are zero. For a right shift the stored operand is emptied from its bottom end for as many cycles as the distance. The window opens only after that. The top result bits are then filled with zeros or with the captured sign bit.

Top module: `bser_shifter`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy_o`, `done_o` and `wr_en_o` are all 0.
- R2: A `start_i` pulse seen while `busy_o` is 0 starts a load phase of exactly `WIDTH` cycles. The load phase begins on the next cycle, and `ser_i` is sampled on each of its cycles, bit 0 first. `busy_o` is 1 and `wr_en_o` is 0 during the whole load phase.
- R3: With `dir_right_i`=0, `wr_en_o` rises on the first cycle after the load phase. The `WIDTH` window bits, read bit 0 first, equal the operand shifted left by the distance, with zeros in the low bits.
- R4: With `dir_right_i`=1 and `arith_i`=0, `wr_en_o` rises exactly N cycles after the load phase, where N is the distance. The window bits equal the operand shifted right logically by N.
- R5: With `dir_right_i`=1 and `arith_i`=1, the window bits equal the operand shifted right arithmetically by N. The fill bit is operand bit `WIDTH`-1, held from the load phase.
- R6: Only the low log2(`WIDTH`) bits of `shamt_i` form the distance. Upper bits have no effect.
- R7: A distance of 0 returns the operand unchanged in all three operations, and the window opens on the first cycle after the load phase.
- R8: `wr_en_o` stays high for exactly `WIDTH` consecutive cycles. On the next cycle `busy_o` is 0 and `done_o` is 1 for one cycle only.
- R9: A `start_i` pulse while `busy_o` is 1 is ignored. Its direction, flag and distance do not change the result in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a transfer when idle |
| dir_right_i | input | 1 | 1 = shift right, 0 = shift left |
| arith_i | input | 1 | 1 = sign fill on right shifts |
| shamt_i | input | SHAMT_IN_W | Shift distance; low log2(WIDTH) bits used |
| ser_i | input | 1 | Serial operand, LSB first, during load phase |
| ser_o | output | 1 | Serial result bit |
| wr_en_o | output | 1 | Result bit valid strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse after the last result bit |

## Verification
A corrupted distance counter shows up in two ways. The window opens on the wrong cycle for right shifts, and the boundary between zeros and data is misplaced for left shifts. Both appear within the first window, at a bit position the sweep over every distance pins down exactly. A wrong sign register or a wrong fill choice changes only the top N result bits. Wrong phase or cycle-count state moves the `wr_en_o` edge or the `done_o` pulse by whole cycles, and the bench counts these cycles against the load phase end.

// File: rtl/bser_shift_pkg.sv
package bser_shift_pkg;

    localparam int unsigned WORD_W_DEF = 32;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LOAD   = 2'd1,
        PH_SKIP   = 2'd2,
        PH_EMIT   = 2'd3
    } phase_e;

    typedef struct packed {
        logic right;
        logic arith;
    } shop_t;

    function automatic logic fill_bit(input shop_t op, input logic sign);
        return op.right & op.arith & sign;
    endfunction

endpackage

// File: rtl/bser_shift_ctrl.sv
module bser_shift_ctrl
    import bser_shift_pkg::*;
#(
    parameter int unsigned WIDTH = WORD_W_DEF,
    localparam int unsigned AW   = $clog2(WIDTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  shop_t         op_i,
    input  logic [AW-1:0] dist_i,
    output shop_t         op_q_o,
    output logic          load_o,
    output logic          load_last_o,
    output logic          shift_o,
    output logic          emit_data_o,
    output logic          win_o,
    output logic          busy_o,
    output logic          done_o
);

    phase_e        phase_q;
    shop_t         op_q;
    logic [AW-1:0] amt_q;
    logic [AW-1:0] cnt_q;
    logic          done_q;
    logic          last;
    logic          amt_zero;

    assign last     = (cnt_q == AW'(WIDTH - 1));
    assign amt_zero = (amt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            op_q    <= '0;
            amt_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        op_q    <= op_i;
                        amt_q   <= dist_i;
                        cnt_q   <= '0;
                        phase_q <= PH_LOAD;
                    end
                end
                PH_LOAD: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last) begin
                        cnt_q   <= '0;
                        phase_q <= (op_q.right && !amt_zero) ? PH_SKIP : PH_EMIT;
                    end
                end
                PH_SKIP: begin
                    amt_q <= amt_q - 1'b1;
                    if (amt_q == AW'(1)) begin
                        phase_q <= PH_EMIT;
                    end
                end
                PH_EMIT: begin
                    if (!op_q.right && !amt_zero) begin
                        amt_q <= amt_q - 1'b1;
                    end
                    cnt_q <= cnt_q + 1'b1;
                    if (last) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign op_q_o      = op_q;
    assign load_o      = (phase_q == PH_LOAD);
    assign load_last_o = (phase_q == PH_LOAD) && last;
    assign emit_data_o = (phase_q == PH_EMIT) && (op_q.right || amt_zero);
    assign shift_o     = (phase_q == PH_SKIP) || emit_data_o;
    assign win_o       = (phase_q == PH_EMIT);
    assign busy_o      = (phase_q != PH_IDLE);
    assign done_o      = done_q;

    AST_SKIP_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SKIP) |=> (amt_q + 1'b1 == $past(amt_q))); // R4

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R8

    AST_DONE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> ($past(phase_q) == PH_EMIT)); // R8

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (op_q == $past(op_q))); // R9

    AST_LOAD_NO_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LOAD) |-> !win_o); // R2

endmodule

// File: rtl/bser_shift_dreg.sv
module bser_shift_dreg
    import bser_shift_pkg::*;
#(
    parameter int unsigned WIDTH = WORD_W_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  logic  load_last_i,
    input  logic  shift_i,
    input  shop_t op_i,
    input  logic  ser_i,
    output logic  lsb_o
);

    logic [WIDTH-1:0] data_q;
    logic             sign_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            sign_q <= 1'b0;
        end else begin
            if (load_i) begin
                data_q <= {ser_i, data_q[WIDTH-1:1]};
            end else if (shift_i) begin
                data_q <= {fill_bit(op_i, sign_q), data_q[WIDTH-1:1]};
            end
            if (load_last_i) begin
                sign_q <= ser_i;
            end
        end
    end

    assign lsb_o = data_q[0];

    AST_SIGN_HELD: assert property (@(posedge clk) disable iff (rst)
        !load_last_i |=> $stable(sign_q)); // R5

    AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !shift_i) |=> $stable(data_q)); // R3

endmodule

// File: rtl/bser_shifter.sv
module bser_shifter
    import bser_shift_pkg::*;
#(
    parameter int unsigned WIDTH      = WORD_W_DEF,
    parameter int unsigned SHAMT_IN_W = 8,
    localparam int unsigned AW        = $clog2(WIDTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic                  dir_right_i,
    input  logic                  arith_i,
    input  logic [SHAMT_IN_W-1:0] shamt_i,
    input  logic                  ser_i,
    output logic                  ser_o,
    output logic                  wr_en_o,
    output logic                  busy_o,
    output logic                  done_o
);

    shop_t op_in;
    shop_t op_q;
    logic  load;
    logic  load_last;
    logic  shift;
    logic  emit_data;
    logic  lsb;
    logic  unused_hi;

    assign op_in.right = dir_right_i;
    assign op_in.arith = arith_i;
    assign unused_hi   = ^shamt_i[SHAMT_IN_W-1:AW];

    bser_shift_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .op_i        (op_in),
        .dist_i      (shamt_i[AW-1:0]),
        .op_q_o      (op_q),
        .load_o      (load),
        .load_last_o (load_last),
        .shift_o     (shift),
        .emit_data_o (emit_data),
        .win_o       (wr_en_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    bser_shift_dreg #(.WIDTH(WIDTH)) u_dreg (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .load_last_i (load_last),
        .shift_i     (shift),
        .op_i        (op_q),
        .ser_i       (ser_i),
        .lsb_o       (lsb)
    );

    assign ser_o = emit_data ? lsb : 1'b0;

    AST_WINDOW_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> busy_o); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !wr_en_o); // R8

endmodule

// File: tb/bser_shifter_tb.sv
`timescale 1ns/1ps
module bser_shifter_tb;

    localparam int W = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       dir_right_i = 1'b0;
    logic       arith_i = 1'b0;
    logic [7:0] shamt_i = '0;
    logic       ser_i = 1'b0;
    logic       ser_o, wr_en_o, busy_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bser_shifter #(.WIDTH(W), .SHAMT_IN_W(8)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .dir_right_i(dir_right_i),
        .arith_i(arith_i), .shamt_i(shamt_i), .ser_i(ser_i), .ser_o(ser_o),
        .wr_en_o(wr_en_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] op, input bit right, input bit ar,
                       input logic [7:0] amt, input bit noise, input string req);
        int n;
        int gap;
        logic [31:0] res;
        logic [31:0] exp;
        logic init_bad;
        n = int'(amt[4:0]);
        if (!right)   exp = op << n;
        else if (!ar) exp = op >> n;
        else          exp = $unsigned($signed(op) >>> n);
        start_i = 1'b1; dir_right_i = right; arith_i = ar; shamt_i = amt;
        @(negedge clk);
        start_i = 1'b0;
        init_bad = 1'b0;
        for (int i = 0; i < W; i++) begin
            ser_i = op[i];
            if (noise && i == 5) begin
                start_i = 1'b1; dir_right_i = ~right; arith_i = ~ar; shamt_i = ~amt;
            end
            if (!busy_o || wr_en_o) init_bad = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        chk(32'(init_bad), 32'd0, "R2 load phase busy/no-window");
        gap = 0;
        while (!wr_en_o && gap < 100) begin
            @(negedge clk);
            gap++;
        end
        chk(32'(gap), right ? 32'(n) : 32'd0, n == 0 ? "R7 window delay" :
            (right ? "R4 window delay" : "R3 window delay"));
        for (int k = 0; k < W; k++) begin
            if (!wr_en_o) chk(32'd0, 32'd1, "R8 window continuity");
            res[k] = ser_o;
            @(negedge clk);
        end
        chk(res, exp, req);
        chk({30'd0, busy_o, done_o}, 32'd1, "R8 end: busy low, done high");
        @(negedge clk);
        chk({31'd0, done_o}, 32'd0, "R8 done single cycle");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] ops [2];
        ops[0] = 32'hA5C3_0F96;
        ops[1] = 32'h5A3C_F069;
        repeat (3) @(negedge clk);
        chk({29'd0, busy_o, done_o, wr_en_o}, 32'd0, "R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        chk({29'd0, busy_o, done_o, wr_en_o}, 32'd0, "R1 after reset");
        for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < W; s++) begin
                run(ops[o], 1'b0, 1'b0, 8'(s), s[0], s == 0 ? "R7 left pass" : "R3 left shift");
                run(ops[o], 1'b1, 1'b0, 8'(s), s[1], s == 0 ? "R7 rlog pass" : "R4 right logical");
                run(ops[o], 1'b1, 1'b1, 8'(s), s[2], s == 0 ? "R7 rari pass" : "R5 right arith");
            end
        end
        // R6: upper distance bits ignored (8'hE3 -> 3, 8'hA0 -> 0)
        run(32'h8123_4567, 1'b1, 1'b1, 8'hE3, 1'b0, "R6 upper bits ignored arith");
        run(32'h8123_4567, 1'b0, 1'b0, 8'hA0, 1'b0, "R6 upper bits ignored left");
        // R9: start pulses during a run have no effect
        run(32'hFFFF_0001, 1'b1, 1'b0, 8'd7, 1'b1, "R9 start while busy ignored");
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule